// File: doc/BRIEF.md
# Serial Flash Whole-Array Erase Command Unit

This block is the command side of a serial flash device that receives a whole-array erase over SPI mode 0. It runs on a fast system clock and samples the SPI pins through a synchronizer. While the chip select is low it takes in command bits on SCK rising edges. It makes its decision only when the chip select goes high again. The array erase itself is modelled by a cycle counter of set length and by a fail input that can be driven to simulate an error.

The unit holds three pieces of state: a write-enable latch, a busy flag and an erase-error flag. A host reads all three through a status-read command, which shifts the status byte out on SCK falling edges. The erase is refused in any of these cases:
- the write-enable latch was not set beforehand;
- any sector-protect input is high;
- the chip select is released part-way through a byte.

A refused attempt on a complete erase opcode also clears the write-enable latch. The SPI pins are plain level signals with no valid/ready flow. The master sets the pace through SCK, and the unit never stalls it.

Top module: `flash_chip_erase`

## Requirements
- R1: After reset the status byte reads 0x00 and `sdo_en` is low.
- R2: Opcode 0x06 sets the write-enable latch (status bit 1) when chip select rises after a whole number of bytes. If chip select rises part-way through a byte, the latch is left unchanged.
- R3: After opcode 0x05 the unit shifts the status byte out MSB first on `sdo`, one bit per SCK falling edge, and repeats it for every further byte. Bit 0 is busy, bit 1 is the write-enable latch, bit 5 is the erase error, and all other bits are 0. `sdo_en` is high only within such a read.
- R4: Opcodes 0x60 and 0xC7 are equivalent. Either one starts the erase when chip select rises after 8·k bits (k ≥ 1) with the write-enable latch set and no sector protected. Whole bytes sent after the opcode are ignored.
- R5: An erase opcode with the write-enable latch clear starts nothing and leaves the status unchanged.
- R6: If chip select rises after fewer than 8 bits, no command takes effect. If it rises after 8 or more bits that are not a multiple of 8, no erase starts, and a complete erase opcode clears the write-enable latch.
- R7: If any bit of `protect` is high when chip select rises, no erase starts and the write-enable latch is cleared.
- R8: An accepted erase holds busy for exactly ERASE_CYCLES clock cycles. The write-enable latch reads 0 from the second cycle of busy onward.
- R9: While busy, every opcode except 0x05 is ignored: write enable does not set the latch, and a new erase neither restarts nor extends the current one.
- R10: If `erase_fail` is high in any busy cycle, the error bit is 1 once busy ends. The error bit is cleared when the next erase is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | SPI serial clock, mode 0 |
| cs_n | input | 1 | SPI chip select, active low |
| sdi | input | 1 | SPI data into the device |
| sdo | output | 1 | SPI data out of the device |
| sdo_en | output | 1 | Output enable for `sdo`; when low the pad is high-impedance |
| protect | input | NUM_SECTORS | Per-sector protect/lock flags |
| erase_fail | input | 1 | Injected erase failure, sampled while busy |

## Verification
The assertions assume a few things about the inputs. Every SCK and chip-select level is held for several system clocks, so the synchronizer sees each edge, and SCK is low when chip select changes. `protect` is stable around the chip-select release that commits a command. The bench keeps to these assumptions: it holds each SCK phase for six clocks, leaves quiet gaps around every chip-select edge, and changes `protect` and `erase_fail` only while chip select is high.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_RDSR    = 8'h05;
  localparam logic [7:0] OP_ERASE_A = 8'h60;
  localparam logic [7:0] OP_ERASE_B = 8'hC7;

  localparam int ST_BUSY = 0;
  localparam int ST_WEL  = 1;
  localparam int ST_EPE  = 5;

  // summary of a finished chip-select frame
  typedef struct packed {
    logic       valid;     // one-cycle pulse on chip-select release
    logic       complete;  // at least one whole opcode byte arrived
    logic       aligned;   // complete and bit count is a byte multiple
    logic [7:0] op;
  } frame_end_t;

  function automatic logic is_erase(input logic [7:0] op);
    return (op == OP_ERASE_A) || (op == OP_ERASE_B);
  endfunction

endpackage

// File: rtl/fe_pin_sync.sv
module fe_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic sdi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise,
  output logic cs_fall,
  output logic cs_n_s,
  output logic sdi_s
);
  logic [STAGES-1:0] sck_q, cs_q, sdi_q;
  logic              sck_prev, cs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= '0;
      cs_q     <= '1;
      sdi_q    <= '0;
      sck_prev <= 1'b0;
      cs_prev  <= 1'b1;
    end else begin
      sck_q    <= {sck_q[STAGES-2:0], sck};
      cs_q     <= {cs_q[STAGES-2:0], cs_n};
      sdi_q    <= {sdi_q[STAGES-2:0], sdi};
      sck_prev <= sck_q[STAGES-1];
      cs_prev  <= cs_q[STAGES-1];
    end
  end

  assign sck_rise = sck_q[STAGES-1] & ~sck_prev;
  assign sck_fall = ~sck_q[STAGES-1] & sck_prev;
  assign cs_rise  = cs_q[STAGES-1] & ~cs_prev;
  assign cs_fall  = ~cs_q[STAGES-1] & cs_prev;
  assign cs_n_s   = cs_q[STAGES-1];
  assign sdi_s    = sdi_q[STAGES-1];
endmodule

// File: rtl/fe_cmd_decode.sv
module fe_cmd_decode
  import flash_erase_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck_rise,
  input  logic       cs_rise,
  input  logic       cs_fall,
  input  logic       cs_n_s,
  input  logic       sdi_s,
  output frame_end_t frame_end,
  output logic       rd_active
);
  logic [2:0] bit_cnt;
  logic       full;
  logic [6:0] shin;
  logic [7:0] op_q;
  logic [7:0] next_op;

  assign next_op = {shin, sdi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      full      <= 1'b0;
      shin      <= '0;
      op_q      <= '0;
      rd_active <= 1'b0;
    end else if (cs_fall) begin
      bit_cnt   <= '0;
      full      <= 1'b0;
      shin      <= '0;
      op_q      <= '0;
      rd_active <= 1'b0;
    end else if (cs_rise) begin
      rd_active <= 1'b0;
    end else if (sck_rise && !cs_n_s) begin
      bit_cnt <= bit_cnt + 3'd1;
      if (!full) begin
        shin <= next_op[6:0];
        if (bit_cnt == 3'd7) begin
          full      <= 1'b1;
          op_q      <= next_op;
          rd_active <= (next_op == OP_RDSR);
        end
      end
    end
  end

  always_comb begin
    frame_end.valid    = cs_rise;
    frame_end.complete = full;
    frame_end.aligned  = full && (bit_cnt == 3'd0);
    frame_end.op       = op_q;
  end
endmodule

// File: rtl/fe_status_tx.sv
module fe_status_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_active,
  input  logic       sck_fall,
  input  logic [7:0] status,
  output logic       sdo,
  output logic       sdo_en
);
  logic [2:0] out_cnt;
  logic [6:0] rest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_cnt <= '0;
      rest    <= '0;
      sdo     <= 1'b0;
    end else if (!rd_active) begin
      out_cnt <= '0;
      rest    <= '0;
      sdo     <= 1'b0;
    end else if (sck_fall) begin
      out_cnt <= out_cnt + 3'd1;
      if (out_cnt == 3'd0) begin
        sdo  <= status[7];
        rest <= status[6:0];
      end else begin
        sdo  <= rest[6];
        rest <= {rest[5:0], 1'b0};
      end
    end
  end

  assign sdo_en = rd_active;
endmodule

// File: rtl/fe_erase_timer.sv
module fe_erase_timer #(
  parameter int ERASE_CYCLES = 1024,
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic fail_in,
  output logic busy,
  output logic epe
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ERASE_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             fail_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      epe       <= 1'b0;
      fail_seen <= 1'b0;
    end else if (start) begin
      busy      <= 1'b1;
      cnt       <= '0;
      epe       <= 1'b0;
      fail_seen <= 1'b0;
    end else if (busy) begin
      fail_seen <= fail_seen | fail_in;
      if (cnt == LAST) begin
        busy <= 1'b0;
        epe  <= fail_seen | fail_in;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_chip_erase.sv
module flash_chip_erase
  import flash_erase_pkg::*;
#(
  parameter int NUM_SECTORS  = 8,
  parameter int ERASE_CYCLES = 1024,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sck,
  input  logic                   cs_n,
  input  logic                   sdi,
  output logic                   sdo,
  output logic                   sdo_en,
  input  logic [NUM_SECTORS-1:0] protect,
  input  logic                   erase_fail
);
  logic       sck_rise, sck_fall, cs_rise, cs_fall, cs_n_s, sdi_s;
  frame_end_t frame_end;
  logic       rd_active;
  logic       busy, epe, wel_q;
  logic       start, reject_clr, wren_set, any_prot, erase_op;
  logic [7:0] status;

  fe_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise),
    .cs_fall(cs_fall), .cs_n_s(cs_n_s), .sdi_s(sdi_s)
  );

  fe_cmd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .cs_rise(cs_rise),
    .cs_fall(cs_fall), .cs_n_s(cs_n_s), .sdi_s(sdi_s),
    .frame_end(frame_end), .rd_active(rd_active)
  );

  assign any_prot = |protect;
  assign erase_op = is_erase(frame_end.op);

  // commit decisions, all on chip-select release and only when idle
  always_comb begin
    start      = frame_end.valid && !busy && frame_end.aligned && erase_op
                 && wel_q && !any_prot;
    reject_clr = frame_end.valid && !busy && frame_end.complete && erase_op
                 && wel_q && (!frame_end.aligned || any_prot);
    wren_set   = frame_end.valid && !busy && frame_end.aligned
                 && (frame_end.op == OP_WREN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wel_q <= 1'b0;
    else if (wren_set)   wel_q <= 1'b1;
    else if (reject_clr) wel_q <= 1'b0;
    else if (busy)       wel_q <= 1'b0;
  end

  fe_erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .fail_in(erase_fail),
    .busy(busy), .epe(epe)
  );

  always_comb begin
    status          = '0;
    status[ST_BUSY] = busy;
    status[ST_WEL]  = wel_q;
    status[ST_EPE]  = epe;
  end

  fe_status_tx u_tx (
    .clk(clk), .rst_n(rst_n), .rd_active(rd_active), .sck_fall(sck_fall),
    .status(status), .sdo(sdo), .sdo_en(sdo_en)
  );
endmodule

// File: rtl/fe_erase_checker.sv
module fe_erase_checker #(
  parameter int NUM_SECTORS  = 8,
  parameter int ERASE_CYCLES = 1024,
  localparam int RUN_W = $clog2(ERASE_CYCLES + 2)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy,
  input logic                   wel,
  input logic                   epe,
  input logic [NUM_SECTORS-1:0] protect
);
  logic [RUN_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else           run_cnt <= '0;
  end

  assert_start_needs_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));

  assert_start_unprotected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(protect) == '0));

  assert_wel_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> !wel);

  assert_busy_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == RUN_W'(ERASE_CYCLES)));

  assert_no_wel_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !wel);

  assert_epe_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !epe);
endmodule

bind flash_chip_erase fe_erase_checker #(
  .NUM_SECTORS(NUM_SECTORS), .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wel(wel_q), .epe(epe),
  .protect(protect)
);

// File: tb/test_flash_chip_erase.sv
module test_flash_chip_erase;
  localparam int NSEC  = 8;
  localparam int ECYC  = 600;
  localparam int HALF  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic [NSEC-1:0] protect = '0;
  logic erase_fail = 1'b0;
  logic sdo, sdo_en;

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_chip_erase #(.NUM_SECTORS(NSEC), .ERASE_CYCLES(ECYC)) i_flash_chip_erase (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .protect(protect), .erase_fail(erase_fail)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int st(input bit busy, input bit wel, input bit epe);
    return (int'(epe) << 5) | (int'(wel) << 1) | int'(busy);
  endfunction

  task automatic send_bits(input logic [31:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      sdi = w[31-i];
      tick(HALF);
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic frame(input logic [31:0] w, input int nbits);
    cs_n = 1'b0;
    tick(HALF);
    send_bits(w, nbits);
    tick(HALF);
    cs_n = 1'b1;
    tick(12);
  endtask

  task automatic read_status(input int nbytes, output logic [15:0] s, output bit en_ok);
    s = '0;
    en_ok = 1'b1;
    cs_n = 1'b0;
    tick(HALF);
    send_bits({8'h05, 24'h0}, 8);
    for (int i = 0; i < 8 * nbytes; i++) begin
      tick(HALF);
      s = {s[14:0], sdo};
      en_ok &= sdo_en;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
    tick(HALF);
    cs_n = 1'b1;
    tick(12);
  endtask

  task automatic status_is(input string tag, input int exp);
    logic [15:0] s;
    bit en;
    read_status(1, s, en);
    check(tag, int'(s[7:0]), exp);
    check({tag, " sdo_en"}, int'(en), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] s2;
    bit en2;
    int t0;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1 reset state
    check("R1 sdo_en idle", int'(sdo_en), 0);
    status_is("R1 reset status", st(0, 0, 0));
    check("R3 sdo_en after read", int'(sdo_en), 0);

    // R2 misaligned write enable, then aligned
    frame({8'h06, 24'hFF0000}, 9);
    status_is("R2 misaligned wren", st(0, 0, 0));
    frame({8'h06, 24'h0}, 8);
    status_is("R2 wren", st(0, 1, 0));
    // R6 fragment shorter than a byte leaves the latch alone
    frame({8'h60, 24'h0}, 5);
    status_is("R6 short frame keeps wel", st(0, 1, 0));
    // clear wel by a misaligned erase opcode
    frame({8'h60, 24'h0}, 10);
    status_is("R6 misaligned erase clears wel", st(0, 0, 0));

    // R5 erase without write enable
    frame({8'hC7, 24'h0}, 8);
    status_is("R5 no wel no erase", st(0, 0, 0));

    // R4/R6 sweep over every frame length 1..24 bits
    for (int n = 1; n <= 24; n++) begin
      bit acc;
      acc = (n >= 8) && (n % 8 == 0);
      frame({8'h06, 24'h0}, 8);
      frame({8'h60, 24'h5AA5C3}, n);
      status_is($sformatf("R4 R6 R8 len %0d", n),
                st(acc, (n < 8), 0));
      if (acc) begin
        tick(ECYC);
        status_is($sformatf("R8 done len %0d", n), st(0, 0, 0));
      end else if (n < 8) begin
        frame({8'h60, 24'h0}, 9);
      end
    end

    // R4 alias opcode with trailing bytes
    frame({8'h06, 24'h0}, 8);
    frame({8'hC7, 24'hFFFFFF}, 32);
    status_is("R4 alias C7", st(1, 0, 0));
    tick(ECYC);
    status_is("R4 alias C7 done", st(0, 0, 0));

    // R7 each protect bit blocks the erase and clears wel
    for (int b = 0; b < NSEC; b++) begin
      frame({8'h06, 24'h0}, 8);
      protect = NSEC'(1) << b;
      frame({8'h60, 24'h0}, 8);
      protect = '0;
      status_is($sformatf("R7 protect bit %0d", b), st(0, 0, 0));
    end

    // R9 commands ignored while busy, no restart
    frame({8'h06, 24'h0}, 8);
    frame({8'h60, 24'h0}, 8);
    t0 = cyc;
    frame({8'h06, 24'h0}, 8);
    status_is("R9 wren ignored busy", st(1, 0, 0));
    frame({8'h60, 24'h0}, 8);
    while (cyc < t0 + ECYC + 10) tick(1);
    status_is("R9 erase not restarted", st(0, 0, 0));

    // R10 injected failure
    erase_fail = 1'b1;
    frame({8'h06, 24'h0}, 8);
    frame({8'h60, 24'h0}, 8);
    tick(ECYC);
    erase_fail = 1'b0;
    status_is("R10 epe set", st(0, 0, 1));
    frame({8'h06, 24'h0}, 8);
    status_is("R10 epe kept wel set", st(0, 1, 1));
    frame({8'hC7, 24'h0}, 8);
    // R3 two-byte status read repeats the byte
    read_status(2, s2, en2);
    check("R3 R10 two-byte status", int'(s2), (st(1, 0, 0) << 8) | st(1, 0, 0));
    check("R3 sdo_en during read", int'(en2), 1);
    tick(ECYC);
    status_is("R10 clean erase", st(0, 0, 0));

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule